// File: doc/BRIEF.md
# Multiphase Phase-Count Detection Sequencer

This block chooses how many power phases a multiphase buck controller runs, then sequences the PWM drive for those phases. When enable rises, the outputs for phases 3 and 4 go into a weak sensing drive. Two digital comparator flags report whether each of those pins is held low by an external strap. On the second oscillator tick after enable, the block latches a phase count of 2, 3 or 4 and leaves sensing mode.

After detection, every oscillator tick starts one pulse. The pulses rotate over the active phases only. Phases 1 and 2 are always active. A phase found strapped low stays silent until enable is dropped. Dropping enable clears everything, and detection runs again on the next enable.

Top module: `phase_count_seq`

## Requirements
- R1: While `en` is low, `pwm_out`, `sense_mode` and `phase_cnt` are all zero in the same cycle, and oscillator ticks have no effect.
- R2: From the cycle `en` is high until the second oscillator tick has been sampled, `sense_mode` is 2'b11 (bit 0 = phase 3 pin, bit 1 = phase 4 pin), `pwm_out` is zero and `phase_cnt` is zero.
- R3: The flags are sampled at the clock edge that sees the second tick. Flag value 1 means the pin is grounded. If `low3_flag`=1, the count is 2, whatever `low4_flag` is. If only `low4_flag`=1, the count is 3. If neither flag is 1, the count is 4. `phase_cnt` shows this value from the next cycle on.
- R4: From the cycle after the second tick, `sense_mode` is 2'b00.
- R5: After detection, each tick starts one pulse. Pulses rotate over phases 1..N in order, where bit i-1 of `pwm_out` drives phase i and N is the latched count. The first tick after detection selects phase 1. At most one `pwm_out` bit is high at a time.
- R6: A pulse is high for min(`duty_req`, TICK_PERIOD-1) cycles, starting the cycle after the tick edge. A request of 0 gives no pulse, but the rotation still advances to the next phase.
- R7: When the count is 3, phase 4 never pulses. When the count is 2, phases 3 and 4 never pulse.
- R8: While `en` stays high, changes on the flags after detection have no effect on `phase_cnt`.
- R9: Dropping `en` clears the latched count and forces `pwm_out` to zero, even in the middle of a pulse. The next enable repeats detection and restarts the rotation at phase 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Controller enable |
| osc_tick | input | 1 | One-cycle oscillator tick |
| low3_flag | input | 1 | Comparator flag: phase 3 pin below threshold |
| low4_flag | input | 1 | Comparator flag: phase 4 pin below threshold |
| duty_req | input | DUTY_W | Requested pulse width in clock cycles |
| sense_mode | output | 2 | Weak sensing drive for the phase 3 and phase 4 pins |
| pwm_out | output | 4 | PWM drive for phases 1..4 |
| phase_cnt | output | 3 | Latched phase count, 0 before detection |

## Verification
All outputs are gated by `en` without a register, so the effect of dropping enable is checked one time step after the change, in the same cycle. The latched count and the release of sensing mode are due one cycle after the edge that samples the second tick. A pulse is expected high on the 1st through d-th falling edge after the tick edge, where d is the capped width, and low on the remaining edges up to the next tick. The bench drives inputs and samples outputs on falling edges. It compares each sample with a value it computes from the requirements: a capped-width function, a count-from-flags function, and the rotation index.

// File: rtl/phase_count_seq.sv
module phase_count_seq #(
  parameter int TICK_PERIOD = 16,
  parameter int DUTY_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              osc_tick,
  input  logic              low3_flag,
  input  logic              low4_flag,
  input  logic [DUTY_W-1:0] duty_req,
  output logic [1:0]        sense_mode,
  output logic [3:0]        pwm_out,
  output logic [2:0]        phase_cnt
);
  localparam logic [DUTY_W-1:0] CAP = DUTY_W'(TICK_PERIOD - 1);

  logic              run_q, seen_q;
  logic [2:0]        cnt_q;
  logic [1:0]        ptr_q, act_q;
  logic [DUTY_W-1:0] rem_q;

  wire [DUTY_W-1:0] width   = (duty_req > CAP) ? CAP : duty_req;
  wire [2:0]        det_cnt = low3_flag ? 3'd2 : (low4_flag ? 3'd3 : 3'd4);
  wire [1:0]        ptr_nxt = (({1'b0, ptr_q} + 3'd1) >= cnt_q) ? 2'd0 : ptr_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !en) begin
      run_q  <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
      ptr_q  <= '0;
      act_q  <= '0;
      rem_q  <= '0;
    end else if (!run_q) begin
      if (osc_tick) begin
        if (seen_q) begin
          run_q <= 1'b1;
          cnt_q <= det_cnt;
        end else begin
          seen_q <= 1'b1;
        end
      end
    end else begin
      if (rem_q != '0) rem_q <= rem_q - 1'b1;
      if (osc_tick) begin
        act_q <= ptr_q;
        rem_q <= width;
        ptr_q <= ptr_nxt;
      end
    end
  end

  assign sense_mode = {2{en & ~run_q}};
  assign pwm_out    = (en && run_q && rem_q != '0) ? 4'(4'b0001 << act_q) : 4'b0000;
  assign phase_cnt  = en ? cnt_q : 3'd0;

  p_off_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (pwm_out == 4'b0 && sense_mode == 2'b0 && phase_cnt == 3'd0));
  p_quiet_during_sense_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sense_mode != 2'b0) |-> (pwm_out == 4'b0 && phase_cnt == 3'd0));
  p_count_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_cnt == 3'd0 || phase_cnt == 3'd2 || phase_cnt == 3'd3 || phase_cnt == 3'd4));
  p_sense_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_cnt != 3'd0) |-> (sense_mode == 2'b0));
  p_single_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pwm_out));
  p_width_capped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= CAP);
  p_three_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_cnt == 3'd3) |-> !pwm_out[3]);
  p_two_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_cnt == 3'd2) |-> (pwm_out[3:2] == 2'b00));
  p_count_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && phase_cnt != 3'd0) |=> (!en || $stable(phase_cnt)));
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!en || phase_cnt == 3'd0));
endmodule

// File: tb/sim_phase_count_seq.sv
module sim_phase_count_seq;
  localparam int P = 16;
  localparam int DW = 5;

  logic clk = 0, rst_n = 0, en = 0, osc_tick = 0, low3 = 0, low4 = 0;
  logic [DW-1:0] duty = '0;
  logic [1:0] sense_mode;
  logic [3:0] pwm_out;
  logic [2:0] phase_cnt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  phase_count_seq #(.TICK_PERIOD(P), .DUTY_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .osc_tick(osc_tick),
    .low3_flag(low3), .low4_flag(low4), .duty_req(duty),
    .sense_mode(sense_mode), .pwm_out(pwm_out), .phase_cnt(phase_cnt));

  function automatic int exp_cnt(bit f3, bit f4);
    return f3 ? 2 : (f4 ? 3 : 4);
  endfunction

  function automatic int exp_width(int d);
    return (d > P - 1) ? P - 1 : d;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_check(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      osc_tick = (i == 1);
      #1;
      chk("R1 pwm", pwm_out, 0);
      chk("R1 sense", sense_mode, 0);
      chk("R1 cnt", phase_cnt, 0);
    end
    osc_tick = 0;
  endtask

  task automatic detect(bit f3, bit f4);
    @(negedge clk);
    low3 = f3; low4 = f4; en = 1;
    #1;
    chk("R2 sense", sense_mode, 3);
    chk("R2 pwm", pwm_out, 0);
    for (int t = 0; t < 2; t++) begin
      for (int g = 0; g < 1 + int'($urandom_range(4)); g++) begin
        @(negedge clk);
        chk("R2 pwm", pwm_out, 0);
        chk("R2 cnt", phase_cnt, 0);
        chk("R2 sense", sense_mode, 3);
      end
      osc_tick = 1;
      @(negedge clk);
      osc_tick = 0;
      if (t == 0) begin
        chk("R2 sense after one tick", sense_mode, 3);
        chk("R2 cnt after one tick", phase_cnt, 0);
      end
    end
    chk("R3 count", phase_cnt, exp_cnt(f3, f4));
    chk("R4 sense released", sense_mode, 0);
    chk("R2 no pulse yet", pwm_out, 0);
  endtask

  task automatic fire(int d, int ph, int n);
    int w;
    w = exp_width(d);
    duty = DW'(d);
    osc_tick = 1;
    for (int c = 1; c <= P; c++) begin
      @(negedge clk);
      osc_tick = 0;
      chk((d == 0) ? "R6 zero width" : "R5/R6 pulse", pwm_out, (c <= w) ? (1 << ph) : 0);
      if (ph >= n) chk("R7 disabled phase", ph, -1);
    end
    low3 = 1'($urandom); low4 = 1'($urandom);
  endtask

  task automatic session(bit f3, bit f4, int nfire, bit directed);
    int n;
    n = exp_cnt(f3, f4);
    detect(f3, f4);
    for (int k = 0; k < nfire; k++) begin
      int d;
      if (directed) d = (k % 4 == 0) ? 31 : (k % 4 == 1) ? 0 : (k % 4 == 2) ? 15 : 1;
      else d = int'($urandom_range(31));
      fire(d, k % n, n);
      chk("R8 count held", phase_cnt, n);
    end
    @(negedge clk);
    en = 0;
    #1;
    chk("R9 pwm cleared", pwm_out, 0);
    chk("R9 count cleared", phase_cnt, 0);
    idle_check(3);
  endtask

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    chk("R1 reset pwm", pwm_out, 0);
    chk("R1 reset cnt", phase_cnt, 0);
    chk("R1 reset sense", sense_mode, 0);
    rst_n = 1;
    idle_check(4);

    session(0, 0, 9, 1);
    session(0, 1, 7, 1);
    session(1, 1, 6, 1);
    session(1, 0, 6, 1);

    detect(0, 0);
    fire(12, 0, 4);
    duty = 10;
    osc_tick = 1;
    @(negedge clk);
    osc_tick = 0;
    chk("R5 second phase", pwm_out, 2);
    @(negedge clk);
    en = 0;
    #1;
    chk("R9 mid-pulse pwm", pwm_out, 0);
    chk("R9 mid-pulse cnt", phase_cnt, 0);
    idle_check(3);
    session(0, 1, 4, 1);

    for (int s = 0; s < 60; s++) begin
      bit f3, f4;
      f3 = 1'($urandom); f4 = 1'($urandom);
      session(f3, f4, 4 + int'($urandom_range(8)), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    #(5 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule